// File: doc/BRIEF.md
# Multicycle Phase-Sequenced 16-bit Processor Core

This block is the control unit and datapath of a small 16-bit load/store processor. Each instruction passes through an explicit phase state machine: fetch, decode, address evaluation, operand fetch, execute and result write. The machine moves only through the phases that the opcode needs. All memory traffic goes through an address staging register and a data staging register, and those two registers drive the memory pins directly. The memory is synchronous and word addressed, and it returns read data one cycle after the read strobe.

The core has eight 16-bit general registers and a program counter, which both reset to zero. It supports:
- register-to-register ADD, AND and NOT;
- a load and a store that form their address from a base register plus a signed 6-bit offset;
- a jump through a register;
- a branch on a register being zero, with a signed 9-bit offset relative to the incremented program counter.

Any other opcode passes through decode as a no-op. Execution starts at address 0 after reset.

Top module: `seq16_core`

## Requirements
- R1: While reset is high both memory strobes stay low. The first memory read after reset is a fetch from address 0.
- R2: A fetch takes six cycles. The read strobe is high for exactly one cycle, in the third cycle, with the program counter value on the address. The next instruction is fetched from that address plus 1 unless a jump or branch changes it.
- R3: The opcode is bits [15:12], with ADD=0001, AND=0101, NOT=1001, load=0110, store=0111, jump=1100 and branch=0000. Any other opcode causes no memory access and no register change. The next fetch starts in the cycle after decode, at the incremented address.
- R4: ADD and AND write R[11:9] with R[8:6] combined with R[2:0], taken modulo 2^16. NOT writes R[11:9] with the inverse of R[8:6].
- R5: ADD, AND and NOT take two cycles after decode and do no memory access.
- R6: A load reads the address R[8:6] plus the sign-extended bits [5:0]. The strobe is a single-cycle read in the third cycle after decode. The load writes the word read to R[11:9] and takes five cycles after decode.
- R7: A store writes R[11:9] to the address R[8:6] plus the sign-extended bits [5:0]. The strobe is a single-cycle write in the fourth cycle after decode. Address and data are already steady in the cycle before the strobe.
- R8: A jump takes one cycle after decode. The next fetch is from the address held in R[8:6].
- R9: A branch takes one cycle after decode. If R[11:9] is zero, the next fetch is from the incremented address plus the sign-extended bits [8:0]. Otherwise the next fetch is from the incremented address.
- R10: The read and write strobes are never high in the same cycle, and each strobe lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Word address, driven by the address staging register |
| mem_wdata | output | 16 | Write data, driven by the data staging register |
| mem_rd | output | 1 | Read strobe, one cycle |
| mem_wr | output | 1 | Write strobe, one cycle |
| mem_rdata | input | 16 | Read data, valid the cycle after the read strobe |

## Verification
The bench drives a program that covers the following cases, and each one exposes a specific kind of fault:
- Sign extension is exercised with negative load and store offsets. Extending with zeros would send those accesses 64 words away.
- Loading 0x8001 and then doubling it checks that ADD wraps.
- An undefined opcode checks the no-op path. A core that mishandles it would show bus traffic or a late next fetch.
- A branch on a nonzero register is followed by a branch on a zero register. The taken branch skips a store that would mark memory. Inverting the condition, or adding the offset to the unincremented address, moves the next fetch address.
- Phase counts are compared cycle by cycle for every opcode class. A skipped or extra phase shifts the strobe out of its expected cycle.

// File: rtl/seq16_pkg.sv
package seq16_pkg;

  localparam int OP_W    = 4;
  localparam int OFF_W   = 6;
  localparam int BOFF_W  = 9;

  localparam logic [OP_W-1:0] OPC_ADD = 4'b0001;
  localparam logic [OP_W-1:0] OPC_AND = 4'b0101;
  localparam logic [OP_W-1:0] OPC_NOT = 4'b1001;
  localparam logic [OP_W-1:0] OPC_LDR = 4'b0110;
  localparam logic [OP_W-1:0] OPC_STR = 4'b0111;
  localparam logic [OP_W-1:0] OPC_JMP = 4'b1100;
  localparam logic [OP_W-1:0] OPC_BR  = 4'b0000;

  typedef enum logic [1:0] {
    ALU_ADD,
    ALU_AND,
    ALU_NOT
  } alu_op_t;

  typedef enum logic [2:0] {
    CL_NOP,
    CL_ALU,
    CL_LD,
    CL_ST,
    CL_JMP,
    CL_BR
  } op_class_t;

  typedef enum logic [4:0] {
    PH_FA,   // program counter into address register
    PH_FR,   // raise read strobe
    PH_FW,   // strobe visible, memory samples
    PH_FM,   // capture returned word
    PH_FI,   // load instruction register, step PC
    PH_DEC,  // pick the phase path
    PH_EX,   // ALU result into temp
    PH_AWB,  // temp into destination
    PH_EA,   // base plus offset into address register
    PH_LRD,  // raise read strobe
    PH_LWT,  // strobe visible
    PH_LMD,  // capture loaded word
    PH_LWB,  // loaded word into destination
    PH_SOP,  // source register into data register
    PH_SST,  // raise write strobe
    PH_SWW,  // strobe visible, memory writes
    PH_JMP,
    PH_BR
  } phase_t;

endpackage

// File: rtl/seq16_decode.sv
module seq16_decode
  import seq16_pkg::*;
#(
  parameter int OPW = OP_W
) (
  input  logic [OPW-1:0]        opcode,
  output logic [(1<<OPW)-1:0]   line,
  output op_class_t             cls,
  output alu_op_t               alu_op
);

  localparam int NLINE = 1 << OPW;
  localparam logic [NLINE-1:0] KNOWN =
      (NLINE'(1) << OPC_ADD) | (NLINE'(1) << OPC_AND) | (NLINE'(1) << OPC_NOT) |
      (NLINE'(1) << OPC_LDR) | (NLINE'(1) << OPC_STR) | (NLINE'(1) << OPC_JMP) |
      (NLINE'(1) << OPC_BR);

  // one control line per opcode value
  genvar g;
  for (g = 0; g < NLINE; g++) begin : g_line
    assign line[g] = (opcode == OPW'(g));
  end

  logic known;
  assign known = |(line & KNOWN);

  always_comb begin
    cls = CL_NOP;
    if (!known)                                             cls = CL_NOP;
    else if (line[OPC_ADD] | line[OPC_AND] | line[OPC_NOT]) cls = CL_ALU;
    else if (line[OPC_LDR])                                 cls = CL_LD;
    else if (line[OPC_STR])                                 cls = CL_ST;
    else if (line[OPC_JMP])                                 cls = CL_JMP;
    else                                                    cls = CL_BR;
  end

  always_comb begin
    if (line[OPC_AND])      alu_op = ALU_AND;
    else if (line[OPC_NOT]) alu_op = ALU_NOT;
    else                    alu_op = ALU_ADD;
  end

endmodule

// File: rtl/seq16_regfile.sv
module seq16_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int RIW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [RIW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [RIW-1:0] raddr_a,
  input  logic [RIW-1:0] raddr_b,
  output logic [DW-1:0]  rdata_a,
  output logic [DW-1:0]  rdata_b
);

  logic [DW-1:0] rf [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (we) begin
      rf[waddr] <= wdata;
    end
  end

  assign rdata_a = rf[raddr_a];
  assign rdata_b = rf[raddr_b];

endmodule

// File: rtl/seq16_alu.sv
module seq16_alu
  import seq16_pkg::*;
#(
  parameter int DW = 16
) (
  input  alu_op_t       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);

  always_comb begin
    case (op)
      ALU_AND: y = a & b;
      ALU_NOT: y = ~a;
      default: y = a + b;
    endcase
  end

endmodule

// File: rtl/seq16_ctrl.sv
module seq16_ctrl
  import seq16_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  op_class_t cls,
  output phase_t    phase
);

  phase_t nxt;

  always_comb begin
    nxt = PH_FA;
    case (phase)
      PH_FA:  nxt = PH_FR;
      PH_FR:  nxt = PH_FW;
      PH_FW:  nxt = PH_FM;
      PH_FM:  nxt = PH_FI;
      PH_FI:  nxt = PH_DEC;
      PH_DEC: begin
        case (cls)
          CL_ALU:        nxt = PH_EX;
          CL_LD, CL_ST:  nxt = PH_EA;
          CL_JMP:        nxt = PH_JMP;
          CL_BR:         nxt = PH_BR;
          default:       nxt = PH_FA;
        endcase
      end
      PH_EX:  nxt = PH_AWB;
      PH_EA:  nxt = (cls == CL_LD) ? PH_LRD : PH_SOP;
      PH_LRD: nxt = PH_LWT;
      PH_LWT: nxt = PH_LMD;
      PH_LMD: nxt = PH_LWB;
      PH_SOP: nxt = PH_SST;
      PH_SST: nxt = PH_SWW;
      default: nxt = PH_FA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_FA;
    else     phase <= nxt;
  end

endmodule

// File: rtl/seq16_core.sv
module seq16_core
  import seq16_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8
) (
  input  logic          clk,
  input  logic          rst,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_rd,
  output logic          mem_wr,
  input  logic [DW-1:0] mem_rdata
);

  localparam int RIW    = $clog2(NREG);
  localparam int DR_LSB = 9;
  localparam int BR_LSB = 6;
  localparam int S2_LSB = 0;

  logic [DW-1:0] pc, ir, mar, mdr, tmp;
  logic          rd_q, wr_q;

  phase_t    phase;
  op_class_t cls;
  alu_op_t   alu_op;
  logic [(1<<OP_W)-1:0] op_line;

  logic [RIW-1:0] ra, rb;
  logic [DW-1:0]  rf_a, rf_b, alu_y, rf_wd, ea, boff;
  logic           rf_we;

  seq16_decode #(.OPW(OP_W)) u_dec (
    .opcode (ir[DW-1 -: OP_W]),
    .line   (op_line),
    .cls    (cls),
    .alu_op (alu_op)
  );

  seq16_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .cls   (cls),
    .phase (phase)
  );

  // port b serves the second ALU source, the store source and the branch test
  assign ra = ir[BR_LSB +: RIW];
  assign rb = (cls == CL_ALU) ? ir[S2_LSB +: RIW] : ir[DR_LSB +: RIW];

  assign rf_we = (phase == PH_AWB) || (phase == PH_LWB);
  assign rf_wd = (phase == PH_LWB) ? mdr : tmp;

  seq16_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (rf_we),
    .waddr   (ir[DR_LSB +: RIW]),
    .wdata   (rf_wd),
    .raddr_a (ra),
    .raddr_b (rb),
    .rdata_a (rf_a),
    .rdata_b (rf_b)
  );

  seq16_alu #(.DW(DW)) u_alu (
    .op (alu_op),
    .a  (rf_a),
    .b  (rf_b),
    .y  (alu_y)
  );

  assign ea   = rf_a + {{(DW-OFF_W){ir[OFF_W-1]}}, ir[OFF_W-1:0]};
  assign boff = {{(DW-BOFF_W){ir[BOFF_W-1]}}, ir[BOFF_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      pc   <= '0;
      ir   <= '0;
      mar  <= '0;
      mdr  <= '0;
      tmp  <= '0;
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      case (phase)
        PH_FA:  mar  <= pc;
        PH_FR:  rd_q <= 1'b1;
        PH_FW:  rd_q <= 1'b0;
        PH_FM:  mdr  <= mem_rdata;
        PH_FI: begin
          ir <= mdr;
          pc <= pc + DW'(1);
        end
        PH_EX:  tmp  <= alu_y;
        PH_EA:  mar  <= ea;
        PH_LRD: rd_q <= 1'b1;
        PH_LWT: rd_q <= 1'b0;
        PH_LMD: mdr  <= mem_rdata;
        PH_SOP: mdr  <= rf_b;
        PH_SST: wr_q <= 1'b1;
        PH_SWW: wr_q <= 1'b0;
        PH_JMP: pc   <= rf_a;
        PH_BR:  if (rf_b == '0) pc <= pc + boff;
        default: ;
      endcase
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign mem_rd    = rd_q;
  assign mem_wr    = wr_q;

endmodule

// File: rtl/seq16_core_chk.sv
module seq16_core_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_rd,
  input logic          mem_wr
);

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!mem_rd && !mem_wr));

  p_no_dual_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  p_rd_one_cycle_r10: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  p_wr_one_cycle_r10: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> !mem_wr);

  p_addr_before_rd_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd) |-> $stable(mem_addr));

  p_staged_before_wr_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_wr) |-> ($stable(mem_addr) && $stable(mem_wdata)));

endmodule

bind seq16_core seq16_core_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr)
);

// File: tb/tb_seq16_core.sv
module tb_seq16_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_rd, mem_wr;

  seq16_core dut (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_rdata (mem_rdata)
  );

  always #5 clk = ~clk;

  logic [15:0] bmem [256];   // memory seen by the core
  logic [15:0] mmem [256];   // reference model memory
  logic [15:0] mr [8];
  logic [15:0] mpc;
  logic [33:0] eq [$];
  string       tq [$];
  string       nxt_tag;
  int          n_chk = 0, n_fail = 0, dual = 0;
  bit          run = 1'b0, fin = 1'b0;

  always @(posedge clk) begin
    if (mem_wr) bmem[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= bmem[mem_addr[7:0]];
  end

  task automatic put(bit r, bit w, logic [15:0] a, logic [15:0] d, string t);
    eq.push_back({r, w, a, d});
    tq.push_back(t);
  endtask

  task automatic idle(int n, string t);
    for (int i = 0; i < n; i++) put(1'b0, 1'b0, 16'h0, 16'h0, t);
  endtask

  // behavioural instruction step: pushes the expected bus trace
  task automatic step();
    logic [15:0] ins, ea, o6, o9;
    logic [2:0]  d, b, s2;
    ins = mmem[mpc[7:0]];
    idle(2, "R2");
    put(1'b1, 1'b0, mpc, 16'h0, nxt_tag);
    idle(3, "R2");
    mpc = mpc + 16'd1;
    d  = ins[11:9];
    b  = ins[8:6];
    s2 = ins[2:0];
    o6 = {{10{ins[5]}}, ins[5:0]};
    o9 = {{7{ins[8]}}, ins[8:0]};
    nxt_tag = "R2";
    case (ins[15:12])
      4'b0001: begin mr[d] = mr[b] + mr[s2]; idle(2, "R5"); end
      4'b0101: begin mr[d] = mr[b] & mr[s2]; idle(2, "R5"); end
      4'b1001: begin mr[d] = ~mr[b];         idle(2, "R5"); end
      4'b0110: begin
        ea = mr[b] + o6;
        idle(2, "R6");
        put(1'b1, 1'b0, ea, 16'h0, "R6");
        idle(2, "R6");
        mr[d] = mmem[ea[7:0]];
      end
      4'b0111: begin
        ea = mr[b] + o6;
        idle(3, "R7");
        put(1'b0, 1'b1, ea, mr[d], "R7");
        mmem[ea[7:0]] = mr[d];
      end
      4'b1100: begin mpc = mr[b]; idle(1, "R8"); nxt_tag = "R8"; end
      4'b0000: begin
        if (mr[d] == 16'h0) mpc = mpc + o9;
        idle(1, "R9");
        nxt_tag = "R9";
      end
      default: nxt_tag = "R3";
    endcase
  endtask

  always @(negedge clk) begin
    logic [33:0] e;
    string       t;
    bit          ok;
    if (run) begin
      if (eq.size() == 0) step();
      e = eq.pop_front();
      t = tq.pop_front();
      n_chk++;
      ok = (mem_rd === e[33]) && (mem_wr === e[32]) &&
           (!(e[33] | e[32]) || mem_addr === e[31:16]) &&
           (!e[32] || mem_wdata === e[15:0]);
      if (!ok) begin
        n_fail++;
        $display("FAIL %s: rd/wr/addr/wdata %b/%b/%h/%h expected %b/%b/%h/%h",
                 t, mem_rd, mem_wr, mem_addr, mem_wdata, e[33], e[32], e[31:16], e[15:0]);
      end
      if (mem_rd && mem_wr) dual++;
    end
  end

  task automatic chk(string t, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", t, act, exp);
    end
  endtask

  task automatic wword(int a, logic [15:0] v);
    bmem[a] = v;
    mmem[a] = v;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) wword(i, 16'h0);
    for (int i = 0; i < 8; i++) mr[i] = 16'h0;
    mpc = 16'h0;
    nxt_tag = "R1";
    wword(16'h00, 16'h6E0A);  // load R7 <- [R0+10]
    wword(16'h01, 16'hC1C0);  // jump R7
    wword(16'h0A, 16'h0040);
    wword(16'h20, 16'h1234);
    wword(16'h21, 16'h0F0F);
    wword(16'h22, 16'h8001);
    wword(16'h40, 16'h63E0);  // R1 <- [R7-32]
    wword(16'h41, 16'h65E1);  // R2 <- [R7-31]
    wword(16'h42, 16'h67E2);  // R3 <- [R7-30]
    wword(16'h43, 16'h1842);  // R4 = R1 + R2
    wword(16'h44, 16'h5A42);  // R5 = R1 & R2
    wword(16'h45, 16'h9CFF);  // R6 = ~R3
    wword(16'h46, 16'h16C3);  // R3 = R3 + R3 (wraps)
    wword(16'h47, 16'hF123);  // undefined opcode
    wword(16'h48, 16'h79F0);  // [R7-16] <- R4
    wword(16'h49, 16'h7BF1);  // [R7-15] <- R5
    wword(16'h4A, 16'h7DF2);  // [R7-14] <- R6
    wword(16'h4B, 16'h77F3);  // [R7-13] <- R3
    wword(16'h4C, 16'h0202);  // branch on R1, not taken
    wword(16'h4D, 16'h0002);  // branch on R0, taken to 0x50
    wword(16'h4E, 16'h73F4);  // skipped store
    wword(16'h4F, 16'h73F4);  // skipped store
    wword(16'h50, 16'h75F5);  // [R7-11] <- R2
    wword(16'h51, 16'h6A0A);  // R5 <- [R0+10]
    wword(16'h52, 16'h7A0C);  // [R0+12] <- R5
    wword(16'h53, 16'h01FF);  // branch to self

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 strobes low in reset", {14'h0, mem_rd, mem_wr}, 16'h0);
    @(posedge clk);
    #2 rst = 1'b0;
    run = 1'b1;
    repeat (700) @(posedge clk);
    #1 run = 1'b0;
    @(posedge clk);
    #1;
    chk("R4 ADD result",        bmem[8'h30], 16'h2143);
    chk("R4 AND result",        bmem[8'h31], 16'h0204);
    chk("R4 NOT result",        bmem[8'h32], 16'h7FFE);
    chk("R4 ADD wraps",         bmem[8'h33], 16'h0002);
    chk("R9 taken skips store", bmem[8'h34], 16'h0000);
    chk("R9 target executes",   bmem[8'h35], 16'h0F0F);
    chk("R6 positive offset",   bmem[8'h0C], 16'h0040);
    chk("R10 dual strobe cycles", 16'(dual), 16'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    fin = 1'b1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule